// File: doc/BRIEF.md
# Excitation-Driven Two-Bit Gray Sequencer

This block steps a two-bit state through a fixed cycle of four codes, moving one position on each clock edge at which it is enabled. The state is held in explicitly modelled set/reset flip-flops. A parameter can swap them for J/K flip-flops. Each bit's next value comes only from its flip-flop's input equations, which are derived from the per-bit excitation rules. The block contains no adder and no case table over the state.

For the set/reset variant, the set input of the high bit is the low bit and its reset input is the low bit's complement. The set input of the low bit is the high bit's complement and its reset input is the high bit. The J/K variant uses the same connections on J and K. When the enable is low, every flip-flop receives its hold excitation. A sticky fault flag records any clock edge at which a set/reset flip-flop sees both inputs high. With correct equations that combination never arises, so the flag acts as a guard against a broken excitation network.

Top module: `gray_seq2`

## Requirements
- R1: A clock edge with `rst` high forces (`q1`,`q0`) to 00 and clears `fault`, whatever `en` is. The values are visible right after that edge.
- R2: At each edge with `rst` low and `en` high, (`q1`,`q0`) advances through 00 → 01 → 11 → 10 → 00. The state at step k equals k XOR (k>>1) modulo 4, counted from reset.
- R3: At an edge with `rst` low and `en` low, (`q1`,`q0`) keeps its value.
- R4: Every enabled step changes exactly one of the two output bits.
- R5: The sequence has a period of exactly four enabled steps. After four steps the state repeats, and it differs at one, two and three steps.
- R6: With `KIND` set to the J/K variant, the outputs follow the same order and timing as the set/reset variant for the same `rst`/`en` stimulus.
- R7: `fault` rises after any edge at which a set/reset flip-flop has both inputs high, and it stays high until a reset edge. With the derived equations, it stays 0 throughout.
- R8: A reset edge in the middle of the sequence returns the state to 00, and the next enabled step goes to 01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all flip-flops |
| rst | input | 1 | Synchronous active-high reset to state 00 |
| en | input | 1 | Step enable; low applies the hold excitation |
| q1 | output | 1 | High state bit (flip-flop output) |
| q0 | output | 1 | Low state bit (flip-flop output) |
| fault | output | 1 | Sticky flag for a set and reset asserted together |

## Verification
Every result is due one edge after its stimulus. The state and the fault flag are flip-flop outputs, and the excitation is combinational from the current state and `en`. The bench therefore changes `rst` and `en` on the falling edge and samples one time unit after the next rising edge. It advances its arithmetic model (k XOR k>>1) only when it drove `en` high. Both variants run side by side on the same stimulus, through long enabled runs, a pseudo-random enable pattern and mid-sequence resets.

// File: rtl/gray_seq2_pkg.sv
package gray_seq2_pkg;
  typedef enum logic {FF_SR = 1'b0, FF_JK = 1'b1} ff_kind_e;
  localparam int unsigned STATE_BITS = 2;
endpackage

// File: rtl/gseq_sr_cell.sv
module gseq_sr_cell (
  input  logic clk,
  input  logic rst,
  input  logic s,
  input  logic r,
  output logic q,
  output logic qn,
  output logic clash
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else begin
      unique case ({s, r})
        2'b10:   q <= 1'b1;
        2'b01:   q <= 1'b0;
        default: q <= q;
      endcase
    end
  end
  assign qn    = ~q;
  assign clash = s & r;

  // R7: the excitation network must never drive both inputs high
  a_r7_no_sr_clash: assert property (@(posedge clk) disable iff (rst) !(s && r));
endmodule

// File: rtl/gseq_jk_cell.sv
module gseq_jk_cell (
  input  logic clk,
  input  logic rst,
  input  logic j,
  input  logic k,
  output logic q,
  output logic qn,
  output logic clash
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else begin
      unique case ({j, k})
        2'b10:   q <= 1'b1;
        2'b01:   q <= 1'b0;
        2'b11:   q <= ~q;
        default: q <= q;
      endcase
    end
  end
  assign qn    = ~q;
  assign clash = 1'b0;
endmodule

// File: rtl/gseq_excite.sv
module gseq_excite #(
  parameter int unsigned NB = gray_seq2_pkg::STATE_BITS
) (
  input  logic [NB-1:0] q,
  input  logic [NB-1:0] qn,
  input  logic          en,
  output logic [NB-1:0] set_in,
  output logic [NB-1:0] clr_in
);
  // Bit 1 follows bit 0; bit 0 follows the complement of bit 1.
  always_comb begin
    set_in = '0;
    clr_in = '0;
    if (en) begin
      set_in[1] = q[0];
      clr_in[1] = qn[0];
      set_in[0] = qn[1];
      clr_in[0] = q[1];
    end
  end
endmodule

// File: rtl/gseq_fault_track.sv
module gseq_fault_track #(
  parameter int unsigned NB = gray_seq2_pkg::STATE_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] clash,
  output logic          fault
);
  always_ff @(posedge clk) begin
    if (rst) fault <= 1'b0;
    else     fault <= fault | (|clash);
  end
endmodule

// File: rtl/gray_seq2.sv
module gray_seq2 #(
  parameter gray_seq2_pkg::ff_kind_e KIND = gray_seq2_pkg::FF_SR
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic q1,
  output logic q0,
  output logic fault
);
  localparam int unsigned NB = gray_seq2_pkg::STATE_BITS;

  logic [NB-1:0] q, qn, set_in, clr_in, clash;

  gseq_excite #(.NB(NB)) u_excite (
    .q(q), .qn(qn), .en(en), .set_in(set_in), .clr_in(clr_in)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bit
    if (KIND == gray_seq2_pkg::FF_SR) begin : g_sr
      gseq_sr_cell u_ff (
        .clk(clk), .rst(rst), .s(set_in[b]), .r(clr_in[b]),
        .q(q[b]), .qn(qn[b]), .clash(clash[b])
      );
    end else begin : g_jk
      gseq_jk_cell u_ff (
        .clk(clk), .rst(rst), .j(set_in[b]), .k(clr_in[b]),
        .q(q[b]), .qn(qn[b]), .clash(clash[b])
      );
    end
  end

  gseq_fault_track #(.NB(NB)) u_fault (
    .clk(clk), .rst(rst), .clash(clash), .fault(fault)
  );

  assign q1 = q[1];
  assign q0 = q[0];

  // live is high once at least one edge has passed out of reset
  logic live;
  always_ff @(posedge clk) live <= ~rst;

  // R4: enabled steps flip exactly one bit
  a_r4_one_bit_step: assert property (@(posedge clk) disable iff (rst)
    (live && $past(en)) |-> ($countones(q ^ $past(q)) == 1));
  // R3: disabled edges hold the state
  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (live && !$past(en)) |-> $stable(q));
  // R2: the start state is followed by 01
  a_r2_leave_start: assert property (@(posedge clk) disable iff (rst)
    (live && $past(en) && $past(q) == 2'b00) |-> (q == 2'b01));
  // R7: fault stays set until reset
  a_r7_fault_sticky: assert property (@(posedge clk) disable iff (rst)
    (live && $past(fault)) |-> fault);
endmodule

// File: tb/gray_seq2_tb.sv
module gray_seq2_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic sq1, sq0, sfault, jq1, jq0, jfault;
  int total = 0;
  int bad   = 0;
  int k     = 0;
  logic [1:0] hist [4];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gray_seq2 #(.KIND(gray_seq2_pkg::FF_SR)) u_dut (
    .clk(clk), .rst(rst), .en(en), .q1(sq1), .q0(sq0), .fault(sfault)
  );
  gray_seq2 #(.KIND(gray_seq2_pkg::FF_JK)) u_dut_jk (
    .clk(clk), .rst(rst), .en(en), .q1(jq1), .q0(jq0), .fault(jfault)
  );

  function automatic logic [1:0] ref_state(int idx);
    int m = idx % 4;
    return 2'(m ^ (m >> 1));
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic edge_go(logic r, logic e);
    @(negedge clk);
    rst = r;
    en  = e;
    @(posedge clk);
    #1;
  endtask

  task automatic check_all(logic [1:0] prev);
    logic [1:0] exp_s = ref_state(k);
    chk({sq1, sq0} == exp_s, "R2", {sq1, sq0}, exp_s);
    chk({jq1, jq0} == exp_s, "R6", {jq1, jq0}, exp_s);
    chk(sfault == 1'b0, "R7", sfault, 0);
    chk(jfault == 1'b0, "R7", jfault, 0);
    if (en && !rst)
      chk($countones({sq1, sq0} ^ prev) == 1, "R4", {sq1, sq0} ^ prev, 1);
    else if (!rst)
      chk({sq1, sq0} == prev, "R3", {sq1, sq0}, prev);
  endtask

  task automatic do_reset(logic e);
    edge_go(1'b1, e);
    k = 0;
    chk({sq1, sq0} == 2'b00, "R1", {sq1, sq0}, 0);
    chk({jq1, jq0} == 2'b00, "R1", {jq1, jq0}, 0);
    chk(sfault == 1'b0 && jfault == 1'b0, "R1", sfault, 0);
  endtask

  task automatic step(logic e);
    logic [1:0] prev = {sq1, sq0};
    edge_go(1'b0, e);
    if (e) k++;
    check_all(prev);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr = 8'hA5;
    do_reset(1'b1);
    // R2, R4: long enabled run; R5: period of four
    for (int i = 0; i < 24; i++) begin
      step(1'b1);
      hist[k % 4] = {sq1, sq0};
      if (k >= 4) begin
        chk({sq1, sq0} == ref_state(k - 4), "R5", {sq1, sq0}, ref_state(k - 4));
        chk({sq1, sq0} != ref_state(k - 1) && {sq1, sq0} != ref_state(k - 2)
            && {sq1, sq0} != ref_state(k - 3), "R5", {sq1, sq0}, ref_state(k));
      end
    end
    // R3: idle run holds
    for (int i = 0; i < 6; i++) step(1'b0);
    // R3, R2, R6: pseudo-random enable pattern
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0]);
    end
    // R8: reset from each of the four states, with enable high and low
    for (int s = 0; s < 4; s++) begin
      for (int e = 0; e < 2; e++) begin
        do_reset(1'b1);
        for (int n = 0; n < s; n++) step(1'b1);
        do_reset(e[0]);
        step(1'b1);
        chk({sq1, sq0} == 2'b01, "R8", {sq1, sq0}, 1);
      end
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule